// File: doc/BRIEF.md
# Processor Interrupt Input Conditioner

This block sits between six processor-side input pins and the core. It watches an external interrupt line, a system management interrupt line, a machine check line, a checkstop line, a hard reset line and a soft reset line. It turns them into a four-bit pending-interrupt vector, one combined hard-interrupt request, a halt flag and a one-cycle core reset pulse. All inputs are synchronous to the block clock.

A stored copy of every pin's previous level is kept. Each pin only causes an event in a cycle when its present level differs from that stored copy, so repeating the same level does nothing. The sensitivity differs from pin to pin:

- The two interrupt lines and the soft reset line are plain level inputs.
- Machine check reacts only to a falling edge. Its pending bit then stays set until the core acknowledges it on a separate clear input.
- Checkstop holds the core halted for as long as it is high.
- A rising hard reset produces a single pulse.

Pin vector bit order: 0 external interrupt, 1 system management, 2 machine check, 3 checkstop, 4 hard reset, 5 soft reset. Pending vector bit order: 0 external, 1 system management, 2 machine check, 3 soft reset. All registers clear on the asynchronous active-low reset.

Top module: `intr_pin_cond`

## Requirements
- R1: While reset is held, and in the first cycle after it, the pending vector, hard-interrupt request, halt flag and core reset pulse are all zero.
- R2: Pending bit 0 equals the level of pin bit 0 (active high), one clock after that level is sampled.
- R3: Pending bit 1 equals the level of pin bit 1 (active high), one clock after that level is sampled.
- R4: Pending bit 2 becomes 1 one clock after pin bit 2 is sampled going from 1 to 0. A 0 to 1 transition of that pin never sets the bit.
- R5: Once set, pending bit 2 stays 1 until the clear input is sampled high, and it reads 0 one clock later. A falling edge on pin bit 2 in the same cycle as the clear wins, and the bit stays 1.
- R6: The halt output equals the level of pin bit 3, one clock after that level is sampled.
- R7: Pending bit 3 equals the level of pin bit 5, one clock after that level is sampled.
- R8: The core reset output is high for exactly one cycle, one clock after pin bit 4 is sampled going from 0 to 1. Holding the pin high produces no further pulse.
- R9: A pin held at an unchanged level generates no event. In particular, machine check held low after a clear does not set pending bit 2 again.
- R10: The hard-interrupt request is high exactly when at least one pending bit is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pinIn | input | 6 | Processor input pin levels, bit order as above |
| mchkClr | input | 1 | Core acknowledge that clears the machine check pending bit |
| pendVec | output | 4 | Pending-interrupt vector |
| hardReq | output | 1 | Combined hard-interrupt request |
| haltOut | output | 1 | Core halt flag driven from checkstop |
| coreRstPulse | output | 1 | One-cycle core reset pulse from hard reset |

## Verification
The hardest case to reach from the ports is a machine check falling edge that lands in the same cycle as the clear strobe. That case decides whether a new error is lost while an older one is acknowledged. The directed stimulus builds it on purpose: it raises the pin, sets the bit with a fall, raises the pin again, then lowers the pin and asserts the clear in one cycle. A long random phase toggles all six pins and the clear together, so the same collision and hard-reset re-arm sequences also occur without being planned.

// File: rtl/intr_pin_cond_pkg.sv
package intr_pin_cond_pkg;

  localparam int NUM_PINS = 6;
  localparam int PEND_W   = 4;

  // pin vector positions
  localparam int PIN_EXT  = 0;
  localparam int PIN_SMI  = 1;
  localparam int PIN_MCHK = 2;
  localparam int PIN_CKST = 3;
  localparam int PIN_HRST = 4;
  localparam int PIN_SRST = 5;

  // pending vector positions
  localparam int PND_EXT  = 0;
  localparam int PND_SMI  = 1;
  localparam int PND_MCHK = 2;
  localparam int PND_SRST = 3;

  typedef struct packed {
    logic extLoad;
    logic smiLoad;
    logic mchkSet;
    logic mchkClear;
    logic haltLoad;
    logic srstLoad;
    logic hrstPulse;
  } pinStrobes_t;

endpackage

// File: rtl/pin_event_ctl.sv
module pin_event_ctl
  import intr_pin_cond_pkg::*;
#(
  parameter int PINS = NUM_PINS
) (
  input  logic [PINS-1:0] pinIn,
  input  logic [PINS-1:0] lastLvl,
  input  logic            mchkClr,
  output pinStrobes_t     strobes
);

  logic [PINS-1:0] changed;

  // per-pin change detection: an event exists only when the level moves
  genvar g;
  generate
    for (g = 0; g < PINS; g++) begin : gChange
      assign changed[g] = pinIn[g] ^ lastLvl[g];
    end
  endgenerate

  always_comb begin
    strobes           = '0;
    strobes.extLoad   = changed[PIN_EXT];
    strobes.smiLoad   = changed[PIN_SMI];
    strobes.mchkSet   = changed[PIN_MCHK] & ~pinIn[PIN_MCHK];
    strobes.mchkClear = mchkClr;
    strobes.haltLoad  = changed[PIN_CKST];
    strobes.srstLoad  = changed[PIN_SRST];
    strobes.hrstPulse = changed[PIN_HRST] & pinIn[PIN_HRST];
  end

endmodule

// File: rtl/pin_state_dp.sv
module pin_state_dp
  import intr_pin_cond_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int PW   = PEND_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  pinStrobes_t     strobes,
  output logic [PINS-1:0] lastLvl,
  output logic [PW-1:0]   pendVec,
  output logic            hardReq,
  output logic            haltOut,
  output logic            coreRstPulse
);

  logic [PW-1:0] pendNext;

  always_comb begin
    pendNext = pendVec;
    if (strobes.extLoad)  pendNext[PND_EXT]  = pinIn[PIN_EXT];
    if (strobes.smiLoad)  pendNext[PND_SMI]  = pinIn[PIN_SMI];
    if (strobes.srstLoad) pendNext[PND_SRST] = pinIn[PIN_SRST];
    // a new fall outranks an acknowledge in the same cycle
    if (strobes.mchkSet)        pendNext[PND_MCHK] = 1'b1;
    else if (strobes.mchkClear) pendNext[PND_MCHK] = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastLvl      <= '0;
      pendVec      <= '0;
      haltOut      <= 1'b0;
      coreRstPulse <= 1'b0;
    end else begin
      lastLvl      <= pinIn;
      pendVec      <= pendNext;
      coreRstPulse <= strobes.hrstPulse;
      if (strobes.haltLoad) haltOut <= pinIn[PIN_CKST];
    end
  end

  assign hardReq = |pendVec;

endmodule

// File: rtl/intr_pin_cond.sv
module intr_pin_cond
  import intr_pin_cond_pkg::*;
#(
  parameter int PINS = NUM_PINS,
  parameter int PW   = PEND_W
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] pinIn,
  input  logic            mchkClr,
  output logic [PW-1:0]   pendVec,
  output logic            hardReq,
  output logic            haltOut,
  output logic            coreRstPulse
);

  pinStrobes_t     strobes;
  logic [PINS-1:0] lastLvl;

  pin_event_ctl #(.PINS(PINS)) u_ctl (
    .pinIn   (pinIn),
    .lastLvl (lastLvl),
    .mchkClr (mchkClr),
    .strobes (strobes)
  );

  pin_state_dp #(.PINS(PINS), .PW(PW)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .pinIn        (pinIn),
    .strobes      (strobes),
    .lastLvl      (lastLvl),
    .pendVec      (pendVec),
    .hardReq      (hardReq),
    .haltOut      (haltOut),
    .coreRstPulse (coreRstPulse)
  );

endmodule

// File: rtl/intr_pin_cond_chk.sv
module intr_pin_cond_chk (
  input logic       clk,
  input logic       rstN,
  input logic [5:0] pinIn,
  input logic       mchkClr,
  input logic [3:0] pendVec,
  input logic       hardReq,
  input logic       haltOut,
  input logic       coreRstPulse
);

  logic armed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) armed <= 1'b0;
    else       armed <= 1'b1;
  end

  a_r2_ext_level: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> pendVec[0] == $past(pinIn[0]));

  a_r3_smi_level: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> pendVec[1] == $past(pinIn[1]));

  a_r4_mchk_fall_sets: assert property (@(posedge clk) disable iff (!rstN)
    (armed && !pinIn[2] && $past(pinIn[2])) |=> pendVec[2]);

  a_r5_mchk_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (armed && pendVec[2] && !mchkClr) |=> pendVec[2]);

  a_r6_halt_follows: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> haltOut == $past(pinIn[3]));

  a_r7_srst_level: assert property (@(posedge clk) disable iff (!rstN)
    armed |=> pendVec[3] == $past(pinIn[5]));

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    coreRstPulse |=> !coreRstPulse);

  a_r8_rise_pulses: assert property (@(posedge clk) disable iff (!rstN)
    (armed && pinIn[4] && !$past(pinIn[4])) |=> coreRstPulse);

  a_r10_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    $fell(hardReq) |-> pendVec == 4'b0000);

endmodule

bind intr_pin_cond intr_pin_cond_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .pinIn        (pinIn),
  .mchkClr      (mchkClr),
  .pendVec      (pendVec),
  .hardReq      (hardReq),
  .haltOut      (haltOut),
  .coreRstPulse (coreRstPulse)
);

// File: tb/test_intr_pin_cond.sv
`timescale 1ns/1ps
module test_intr_pin_cond;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [5:0] pinDrv = '0;
  logic       clrDrv = 1'b0;
  logic [3:0] pendVec;
  logic       hardReq, haltOut, coreRstPulse;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit running = 1'b1;

  always #2.5 clk = ~clk;

  intr_pin_cond i_intr_pin_cond (
    .clk(clk), .rstN(rstN), .pinIn(pinDrv), .mchkClr(clrDrv),
    .pendVec(pendVec), .hardReq(hardReq), .haltOut(haltOut),
    .coreRstPulse(coreRstPulse)
  );

  // behavioural reference state
  bit prevPin[6];
  bit mExt, mSmi, mMchk, mSrst, mHalt, mPulse;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      foreach (prevPin[k]) prevPin[k] = 0;
      mExt = 0; mSmi = 0; mMchk = 0; mSrst = 0; mHalt = 0; mPulse = 0;
    end else begin
      mExt  = pinDrv[0];
      mSmi  = pinDrv[1];
      mSrst = pinDrv[5];
      mHalt = pinDrv[3];
      if (prevPin[2] && !pinDrv[2]) mMchk = 1;
      else if (clrDrv)              mMchk = 0;
      mPulse = pinDrv[4] && !prevPin[4];
      for (int k = 0; k < 6; k++) prevPin[k] = pinDrv[k];
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (running && rstN) begin
      check(pendVec[0] == mExt,  "R2 ext pending",  pendVec[0], mExt);
      check(pendVec[1] == mSmi,  "R3 smi pending",  pendVec[1], mSmi);
      check(pendVec[2] == mMchk, "R4/R5 mchk pending", pendVec[2], mMchk);
      check(pendVec[3] == mSrst, "R7 srst pending", pendVec[3], mSrst);
      check(haltOut == mHalt,    "R6 halt",         haltOut, mHalt);
      check(coreRstPulse == mPulse, "R8 reset pulse", coreRstPulse, mPulse);
      check(hardReq == (mExt | mSmi | mMchk | mSrst), "R10 hard request",
            hardReq, mExt | mSmi | mMchk | mSrst);
    end
  end

  task automatic tick(input logic [5:0] p, input logic c);
    @(negedge clk);
    pinDrv = p;
    clrDrv = c;
    @(posedge clk);
    #1;
  endtask

  initial begin
    while (running) begin
      @(posedge clk);
      cycles++;
      if (cycles > 60000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 60000);
        running = 1'b0;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check({pendVec, hardReq, haltOut, coreRstPulse} == '0, "R1 in reset",
          {pendVec, hardReq, haltOut, coreRstPulse}, 0);
    @(negedge clk) rstN = 1'b1;
    @(posedge clk); #1;
    check({pendVec, hardReq, haltOut, coreRstPulse} == '0, "R1 after release",
          {pendVec, hardReq, haltOut, coreRstPulse}, 0);

    // R2 / R3 / R7: level lines
    tick(6'b000001, 0); check(pendVec == 4'b0001, "R2 ext set", pendVec, 1);
    tick(6'b000011, 0); check(pendVec == 4'b0011, "R3 smi set", pendVec, 3);
    tick(6'b100010, 0); check(pendVec == 4'b1010, "R7 srst set", pendVec, 10);
    tick(6'b000000, 0); check(pendVec == 4'b0000 && !hardReq, "R10 all clear",
                              pendVec, 0);

    // R4: rising machine check does not set, falling does
    tick(6'b000100, 0); check(pendVec[2] == 0, "R4 rise ignored", pendVec[2], 0);
    tick(6'b000000, 0); check(pendVec[2] == 1 && hardReq, "R4 fall sets", pendVec[2], 1);
    tick(6'b000000, 0); check(pendVec[2] == 1, "R5 sticky", pendVec[2], 1);
    tick(6'b000000, 1); check(pendVec[2] == 0, "R5 clear", pendVec[2], 0);
    tick(6'b000000, 0); check(pendVec[2] == 0, "R9 held low no re-set", pendVec[2], 0);
    // R5: fall coinciding with clear keeps the bit
    tick(6'b000100, 0);
    tick(6'b000000, 0);
    tick(6'b000100, 0);
    tick(6'b000000, 1); check(pendVec[2] == 1, "R5 fall beats clear", pendVec[2], 1);
    tick(6'b000000, 1); check(pendVec[2] == 0, "R5 later clear", pendVec[2], 0);

    // R6: checkstop halts while high
    tick(6'b001000, 0); check(haltOut == 1, "R6 halt on", haltOut, 1);
    tick(6'b001000, 0); check(haltOut == 1 && !hardReq, "R6 halt held", haltOut, 1);
    tick(6'b000000, 0); check(haltOut == 0, "R6 halt off", haltOut, 0);

    // R8: single pulse on hard reset rise
    tick(6'b010000, 0); check(coreRstPulse == 1, "R8 pulse", coreRstPulse, 1);
    tick(6'b010000, 0); check(coreRstPulse == 0, "R8 held no pulse", coreRstPulse, 0);
    tick(6'b010000, 0); check(coreRstPulse == 0, "R9 held again", coreRstPulse, 0);
    tick(6'b000000, 0); check(coreRstPulse == 0, "R8 fall no pulse", coreRstPulse, 0);

    // random mix, compared every cycle
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] p;
      logic c;
      p = 6'($urandom);
      c = ($urandom % 4) == 0;
      if ($urandom % 3 != 0) p = pinDrv ^ (6'b1 << ($urandom % 6));
      tick(p, c);
    end

    running = 1'b0;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule